// File: doc/BRIEF.md
# Dual-Clock Resettable Field Delay Memory

This block is a serial field store. Its write port and its read port each run on their own clock, and the two clocks need not be related. Each port has an address pointer that steps through the array one word per access. A reset strobe on a port sends that port's pointer back to the first location. Data written a given number of words after a write reset is read back the same number of words after a read reset. The spacing between the two resets therefore sets the delay through the store.

Each port has two enables. The advance enable freezes the port: no access is made and the pointer holds. The second enable lets the pointer keep moving but blocks the data. On the write side it masks the store, so earlier contents survive and only selected locations are overwritten. On the read side it blanks the output, so the word at that address is skipped. Neither pointer carries full or empty tracking. Both wrap to the first location after the last one. Either clock may stop for any length of time without loss of contents or pointer state.

Top module: `field_delay_mem`

## Requirements
- R1: A write reset sampled on a write clock edge accesses location 0 in that cycle, whatever the write advance enable is. The next write access goes to location 1.
- R2: When the write advance enable is low and there is no write reset, the write edge stores nothing and the write pointer holds.
- R3: When the write mask enable is low during a write access, the addressed location keeps its old word. The write pointer still advances.
- R4: A read reset sampled on a read clock edge presents the word at location 0 on the data output right after that same edge, with no extra cycle. Later accesses go to location 1 and onward.
- R5: When the read advance enable is low and there is no read reset, the read pointer holds. The data output and the valid flag also keep their previous values.
- R6: When the output enable is low during a read access, the valid flag goes low and the data lines are released to high impedance. The read pointer still advances, so that word is skipped.
- R7: Both pointers wrap from location DEPTH-1 back to location 0. No full or empty flag exists.
- R8: After a write reset and a read reset, the sequence of words read matches the sequence written to the same addresses, including masked locations. Writes and reads run on unrelated clock rates.
- R9: Stopping either clock for a long time loses no stored word and no pointer position. Accesses resume from the next address once the clock restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write port clock |
| wrst | input | 1 | Write pointer reset strobe, sampled on wclk |
| wen | input | 1 | Write advance enable |
| ien | input | 1 | Write mask enable (low keeps the old word) |
| din | input | WIDTH | Write data |
| rclk | input | 1 | Read port clock |
| rrst | input | 1 | Read pointer reset strobe, sampled on rclk |
| ren | input | 1 | Read advance enable |
| oen | input | 1 | Output enable (low skips the word) |
| dout | output | WIDTH | Read data, high impedance while not valid |
| dout_vld | output | 1 | High when dout carries a read word |

## Verification
The bench builds the block with WIDTH of 12 and DEPTH of 12. Because the depth is not a power of two, the wrap must use an explicit compare. The bit width of the pointer alone would not produce it. Twelve locations also let a short random run wrap both pointers many times. Masked writes and skipped reads then land on locations that are revisited with older data still in place. The read clock differs from the write clock and is stopped during write phases, and the write clock is stopped during read phases, so pointer retention across a halted clock is exercised.

// File: rtl/field_delay_mem.sv
module field_delay_mem #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 64
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wen,
  input  logic             ien,
  input  logic [WIDTH-1:0] din,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             ren,
  input  logic             oen,
  output logic [WIDTH-1:0] dout,
  output logic             dout_vld
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [WIDTH-1:0] rdata;
  logic             rvld;

  wire [AW-1:0] wadr = wrst ? '0 : wptr;
  wire [AW-1:0] radr = rrst ? '0 : rptr;
  wire          wgo  = wrst | wen;
  wire          rgo  = rrst | ren;

  always_ff @(posedge wclk) begin
    if (wgo) begin
      if (ien) mem[wadr] <= din;
      wptr <= (wadr == LAST) ? '0 : wadr + 1'b1;
    end
  end

  always_ff @(posedge rclk) begin
    if (rgo) begin
      rdata <= mem[radr];
      rvld  <= oen;
      rptr  <= (radr == LAST) ? '0 : radr + 1'b1;
    end
  end

  assign dout     = rvld ? rdata : {WIDTH{1'bz}};
  assign dout_vld = rvld;
endmodule

module field_delay_mem_chk #(
  parameter int AW    = 6,
  parameter int DEPTH = 64
) (
  input logic          wclk,
  input logic          wrst,
  input logic          wen,
  input logic          rclk,
  input logic          rrst,
  input logic          ren,
  input logic          oen,
  input logic          dout_vld,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr
);
  localparam logic [AW-1:0] ONE  = AW'(1 % DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  logic wok, rok;

  always_ff @(posedge wclk) if (wrst) wok <= 1'b1;
  always_ff @(posedge rclk) if (rrst) rok <= 1'b1;

  p_wrst_zero_r1: assert property (@(posedge wclk) disable iff (wok !== 1'b1)
    wrst |=> wptr == ONE);
  p_whold_r2: assert property (@(posedge wclk) disable iff (wok !== 1'b1)
    (!wrst && !wen) |=> $stable(wptr));
  p_wstep_r3: assert property (@(posedge wclk) disable iff (wok !== 1'b1)
    (!wrst && wen && wptr != LAST) |=> wptr == $past(wptr) + AW'(1));
  p_wwrap_r7: assert property (@(posedge wclk) disable iff (wok !== 1'b1)
    (!wrst && wen && wptr == LAST) |=> wptr == '0);
  p_rrst_zero_r4: assert property (@(posedge rclk) disable iff (rok !== 1'b1)
    rrst |=> rptr == ONE);
  p_rhold_r5: assert property (@(posedge rclk) disable iff (rok !== 1'b1)
    (!rrst && !ren) |=> ($stable(rptr) && $stable(dout_vld)));
  p_skip_r6: assert property (@(posedge rclk) disable iff (rok !== 1'b1)
    ((rrst || ren) && !oen) |=> !dout_vld);
  p_rwrap_r7: assert property (@(posedge rclk) disable iff (rok !== 1'b1)
    (!rrst && ren && rptr == LAST) |=> rptr == '0);
endmodule

bind field_delay_mem field_delay_mem_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .wrst(wrst), .wen(wen), .rclk(rclk), .rrst(rrst),
  .ren(ren), .oen(oen), .dout_vld(dout_vld), .wptr(wptr), .rptr(rptr)
);

// File: tb/field_delay_mem_test.sv
module field_delay_mem_test;
  localparam int W = 12;
  localparam int D = 12;

  logic wclk = 0, rclk = 0, wrun = 1, rrun = 0;
  logic wrst = 0, wen = 0, ien = 0, rrst = 0, ren = 0, oen = 0;
  logic [W-1:0] din = '0;
  wire  [W-1:0] dout;
  wire          dout_vld;

  int checks = 0, errors = 0;
  logic [W-1:0] mdl [D];
  int mwp = 0, mrp = 0;
  logic [W-1:0] exp_dat = '0;
  logic exp_vld = 0;

  field_delay_mem #(.WIDTH(W), .DEPTH(D)) uut (
    .wclk(wclk), .wrst(wrst), .wen(wen), .ien(ien), .din(din),
    .rclk(rclk), .rrst(rrst), .ren(ren), .oen(oen),
    .dout(dout), .dout_vld(dout_vld));

  always #2 wclk = wrun ? ~wclk : wclk;
  always #5 rclk = rrun ? ~rclk : rclk;

  function automatic int nxt(int a);
    return (a == D - 1) ? 0 : a + 1;
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit r, bit we, bit ie, logic [W-1:0] d);
    int a;
    @(negedge wclk);
    wrst = r; wen = we; ien = ie; din = d;
    @(posedge wclk);
    if (r || we) begin
      a = r ? 0 : mwp;
      if (ie) mdl[a] = d;
      mwp = nxt(a);
    end
  endtask

  task automatic rd(bit r, bit re, bit oe, string req);
    int a;
    @(negedge rclk);
    rrst = r; ren = re; oen = oe;
    @(posedge rclk);
    #1;
    if (r || re) begin
      a = r ? 0 : mrp;
      exp_vld = oe;
      if (oe) exp_dat = mdl[a];
      mrp = nxt(a);
    end
    chk(dout_vld === exp_vld, req, {{(W-1){1'b0}}, dout_vld}, {{(W-1){1'b0}}, exp_vld});
    if (exp_vld) chk(dout === exp_dat, req, dout, exp_dat);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    // R1 fill all locations starting from a write reset, ending with a wrap (R7)
    wr(1, 0, 1, 12'hA00);
    for (int i = 1; i < D; i++) wr(0, 1, 1, 12'hA00 + W'(i));
    // R2 frozen writes, R3 masked writes
    wr(0, 0, 1, 12'hFFF);
    wr(0, 1, 0, 12'hEEE);
    // random write mix
    for (int i = 0; i < 40; i++)
      wr(($urandom % 16) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0, W'($urandom));
    // R9 stop write clock, run reads
    wrun = 0; rrun = 1;
    rd(1, 0, 1, "R4");
    rd(0, 0, 1, "R5");
    rd(0, 1, 0, "R6");
    rd(0, 1, 1, "R6");
    for (int i = 0; i < 60; i++)
      rd(($urandom % 16) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0, "R8");
    // R9 stop read clock, write again, resume reads from held pointer
    rrun = 0; wrun = 1;
    for (int i = 0; i < 5; i++) wr(0, 1, 1, W'($urandom));
    wr(1, 1, 0, 12'h123);
    for (int i = 0; i < 30; i++)
      wr(($urandom % 20) == 0, ($urandom % 4) != 0, ($urandom % 3) != 0, W'($urandom));
    wrun = 0; rrun = 1;
    rd(0, 0, 1, "R9");
    rd(0, 1, 1, "R9");
    rd(1, 1, 1, "R4");
    // R7 read pointer wrap over more than one pass
    for (int i = 0; i < 2 * D; i++) rd(0, 1, 1, "R7");
    for (int i = 0; i < 40; i++)
      rd(($urandom % 16) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0, "R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule